// File: doc/BRIEF.md
# Vector Compare and Mask Unit

This block sits beside a vector register file of up to 64 elements. It compares one vector with another vector, or with a scalar, at one element per clock. It writes the boolean outcome of each element into a mask register. Software-visible commands arrive on a command port: start a compare, count the mask's set bits, clear the mask, or set the active vector length. The active length limits every operation. Elements are signed 64-bit integers.

Operand elements reach the unit on a valid/ready stream. Each beat carries element i of both sources. The unit raises `src_ready` only while a compare is running, so the producer may stall at any time by dropping `src_valid`. The command port also uses valid/ready. `cmd_ready` stays low for as long as a compare is consuming elements, so a new command waits until the compare finishes. A downstream arithmetic lane presents an element index on `lane_idx`. It receives a write enable for that index, gated by the vector length and, while masking is on, by the mask.

Top module: `vcm_unit`

## Requirements
- R1: Condition codes are 0 EQ, 1 NE, 2 GT, 3 LT, 4 GE, 5 LE, where GT means the first source is greater than the second. Operands compare as signed two's-complement values. Codes 6 and 7 never hold.
- R2: When `cmd_vs` is 1, `cmd_scalar` replaces the second source for every element, and `src_b` has no effect on the mask.
- R3: After a compare, mask bit i equals the compare outcome of beat i for every i below the vector length. Every bit at or above the vector length is 0. A compare turns masking on (`mask_on` = 1).
- R4: `lane_we` is 1 exactly when `lane_idx` is below the vector length and either masking is off or the mask bit at `lane_idx` is 1.
- R5: A clear command (op 2) sets every mask bit to 0 and turns masking off.
- R6: A count command (op 1) gives `pop_valid` for one cycle, the cycle after the command is accepted. With it, `pop_count` equals the number of 1 bits among the mask positions below the current vector length.
- R7: A set-length command (op 3) sets the vector length to `cmd_scalar`, saturated at 64. After reset the length is 64.
- R8: A compare (op 0) accepts exactly vector-length beats, one per clock while `src_valid` is high. `src_ready` is high only while a compare is active. `cmd_ready` is low for that whole time.
- R9: `done` is high for one cycle, the cycle after the last beat is accepted. With a vector length of 0, it is high the cycle after the compare command is accepted, and no beat is taken.
- R10: After reset, `cmd_ready` is 1, and `src_ready`, `done`, `pop_valid`, `mask_on` and every mask bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 0 compare, 1 count, 2 clear, 3 set length |
| cmd_cond | input | 3 | Condition code for a compare |
| cmd_vs | input | 1 | 1 selects the vector-scalar form |
| cmd_scalar | input | 64 | Scalar operand, or new length for op 3 |
| src_valid | input | 1 | Element pair offered |
| src_ready | output | 1 | Element pair accepted when high with src_valid |
| src_a | input | 64 | Element of the first source |
| src_b | input | 64 | Element of the second source |
| mask_bits | output | 64 | Mask register, bit i for element i |
| mask_on | output | 1 | Masking enabled |
| done | output | 1 | One-cycle pulse at compare end |
| pop_valid | output | 1 | Count result valid |
| pop_count | output | 7 | Number of set mask bits below the length |
| lane_idx | input | 6 | Element index queried by the arithmetic lane |
| lane_we | output | 1 | Write enable for lane_idx |

## Verification
The compare is driven with all eight condition codes on element pairs that include equal values, positive and negative values, and values that differ only in sign. This separates signed from unsigned ordering and shows that GE, LE and NE differ from GT, LT and EQ at equality. The vector-scalar form runs with a second source full of unrelated data, which shows that the scalar is the operand actually used. Compares run at full length, at short lengths, at a saturated length and at zero length, with and without gaps in the element stream. These runs show mask clearing above the length, beat counting under stalls, and the exact cycle of the done pulse. Count, clear and lane write-enable scans follow these compares. They tell apart the masked and unmasked gating, and show whether the count is limited by the length.

// File: rtl/vcm_pkg.sv
`timescale 1ns/1ps
package vcm_pkg;
  localparam int ELEM_W_DEF = 64;
  localparam int MAX_VL_DEF = 64;

  typedef enum logic [1:0] {
    OP_CMP   = 2'd0,
    OP_POP   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_SETVL = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    CC_EQ  = 3'd0,
    CC_NE  = 3'd1,
    CC_GT  = 3'd2,
    CC_LT  = 3'd3,
    CC_GE  = 3'd4,
    CC_LE  = 3'd5,
    CC_NV6 = 3'd6,
    CC_NV7 = 3'd7
  } cond_e;
endpackage

// File: rtl/vcm_compare.sv
`timescale 1ns/1ps
// Six-way signed comparator; unused codes never hold.
module vcm_compare
  import vcm_pkg::*;
#(
  parameter int ELEM_W = ELEM_W_DEF
) (
  input  logic [2:0]        cond,
  input  logic [ELEM_W-1:0] lhs,
  input  logic [ELEM_W-1:0] rhs,
  output logic              hit
);
  logic is_eq, is_lt;

  always_comb begin
    is_eq = (lhs == rhs);
    is_lt = ($signed(lhs) < $signed(rhs));
    case (cond_e'(cond))
      CC_EQ:   hit = is_eq;
      CC_NE:   hit = !is_eq;
      CC_GT:   hit = !is_lt && !is_eq;
      CC_LT:   hit = is_lt;
      CC_GE:   hit = !is_lt;
      CC_LE:   hit = is_lt || is_eq;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/vcm_lenmask.sv
`timescale 1ns/1ps
// Thermometer of active element positions: bit i set when i < vl.
module vcm_lenmask #(
  parameter int MAX_VL = 64,
  localparam int VL_W = $clog2(MAX_VL + 1)
) (
  input  logic [VL_W-1:0]   vl,
  output logic [MAX_VL-1:0] active
);
  for (genvar g = 0; g < MAX_VL; g++) begin : g_pos
    assign active[g] = (VL_W'(g) < vl);
  end
endmodule

// File: rtl/vcm_popcount.sv
`timescale 1ns/1ps
// Counts set bits of the mask restricted to active positions.
module vcm_popcount #(
  parameter int MAX_VL = 64,
  localparam int VL_W = $clog2(MAX_VL + 1)
) (
  input  logic [MAX_VL-1:0] bits,
  input  logic [MAX_VL-1:0] active,
  output logic [VL_W-1:0]   total
);
  always_comb begin
    total = '0;
    for (int k = 0; k < MAX_VL; k++) begin
      total = total + VL_W'(bits[k] & active[k]);
    end
  end
endmodule

// File: rtl/vcm_unit.sv
`timescale 1ns/1ps
module vcm_unit
  import vcm_pkg::*;
#(
  parameter int ELEM_W = ELEM_W_DEF,
  parameter int MAX_VL = MAX_VL_DEF,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [2:0]        cmd_cond,
  input  logic              cmd_vs,
  input  logic [ELEM_W-1:0] cmd_scalar,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [ELEM_W-1:0] src_a,
  input  logic [ELEM_W-1:0] src_b,
  output logic [MAX_VL-1:0] mask_bits,
  output logic              mask_on,
  output logic              done,
  output logic              pop_valid,
  output logic [VL_W-1:0]   pop_count,
  input  logic [IDX_W-1:0]  lane_idx,
  output logic              lane_we
);
  logic              busy_q;
  logic [2:0]        cond_q;
  logic              vs_q;
  logic [ELEM_W-1:0] scal_q;
  logic [VL_W-1:0]   vl_q;
  logic [VL_W-1:0]   idx_q;
  logic [MAX_VL-1:0] mask_q;
  logic              mask_on_q;
  logic              done_q;
  logic              popv_q;
  logic [VL_W-1:0]   popc_q;

  logic [MAX_VL-1:0] active;
  logic [VL_W-1:0]   pop_sum;
  logic [ELEM_W-1:0] rhs;
  logic              hit;
  logic              cmd_fire, beat, last_beat;

  assign cmd_ready = !busy_q;
  assign src_ready = busy_q;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign beat      = src_valid && src_ready;
  assign last_beat = (idx_q + 1'b1) == vl_q;
  assign rhs       = vs_q ? scal_q : src_b;

  vcm_lenmask #(.MAX_VL(MAX_VL)) i_lenmask (
    .vl     (vl_q),
    .active (active)
  );

  vcm_popcount #(.MAX_VL(MAX_VL)) i_popcount (
    .bits   (mask_q),
    .active (active),
    .total  (pop_sum)
  );

  vcm_compare #(.ELEM_W(ELEM_W)) i_compare (
    .cond (cond_q),
    .lhs  (src_a),
    .rhs  (rhs),
    .hit  (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cond_q    <= '0;
      vs_q      <= 1'b0;
      scal_q    <= '0;
      vl_q      <= VL_W'(MAX_VL);
      idx_q     <= '0;
      mask_q    <= '0;
      mask_on_q <= 1'b0;
      done_q    <= 1'b0;
      popv_q    <= 1'b0;
      popc_q    <= '0;
    end else begin
      done_q <= 1'b0;
      popv_q <= 1'b0;
      if (cmd_fire) begin
        case (op_e'(cmd_op))
          OP_CMP: begin
            cond_q    <= cmd_cond;
            vs_q      <= cmd_vs;
            scal_q    <= cmd_scalar;
            mask_q    <= '0;
            mask_on_q <= 1'b1;
            idx_q     <= '0;
            if (vl_q == '0) done_q <= 1'b1;
            else            busy_q <= 1'b1;
          end
          OP_POP: begin
            popv_q <= 1'b1;
            popc_q <= pop_sum;
          end
          OP_CLEAR: begin
            mask_q    <= '0;
            mask_on_q <= 1'b0;
          end
          default: begin
            if (cmd_scalar > ELEM_W'(MAX_VL)) vl_q <= VL_W'(MAX_VL);
            else                              vl_q <= cmd_scalar[VL_W-1:0];
          end
        endcase
      end
      if (beat) begin
        mask_q[idx_q[IDX_W-1:0]] <= hit;
        idx_q <= idx_q + 1'b1;
        if (last_beat) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign mask_bits = mask_q;
  assign mask_on   = mask_on_q;
  assign done      = done_q;
  assign pop_valid = popv_q;
  assign pop_count = popc_q;
  assign lane_we   = active[lane_idx] && (!mask_on_q || mask_q[lane_idx]);
endmodule

// File: rtl/vcm_checker.sv
`timescale 1ns/1ps
module vcm_checker #(
  parameter int MAX_VL = 64,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic              src_ready,
  input logic [MAX_VL-1:0] mask_bits,
  input logic              mask_on,
  input logic              done,
  input logic              pop_valid,
  input logic [VL_W-1:0]   pop_count,
  input logic [IDX_W-1:0]  lane_idx,
  input logic              lane_we
);
  AST_SRC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> !cmd_ready); // R8

  AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd2) |=> (mask_bits == '0 && !mask_on)); // R5

  AST_MASK_GATES_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_on && !mask_bits[lane_idx]) |-> !lane_we); // R4

  AST_POP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> (pop_count <= VL_W'(MAX_VL))); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready && !src_ready)); // R9

  AST_COUNT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd1) |=> pop_valid); // R6
endmodule

bind vcm_unit vcm_checker #(.MAX_VL(MAX_VL)) i_vcm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .src_ready (src_ready),
  .mask_bits (mask_bits),
  .mask_on   (mask_on),
  .done      (done),
  .pop_valid (pop_valid),
  .pop_count (pop_count),
  .lane_idx  (lane_idx),
  .lane_we   (lane_we)
);

// File: tb/test_vcm_unit.sv
`timescale 1ns/1ps
module test_vcm_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [2:0]  cmd_cond = '0;
  logic        cmd_vs = 1'b0;
  logic [63:0] cmd_scalar = '0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [63:0] mask_bits;
  logic        mask_on;
  logic        done;
  logic        pop_valid;
  logic [6:0]  pop_count;
  logic [5:0]  lane_idx = '0;
  logic        lane_we;

  int n_run = 0;
  int n_fail = 0;

  logic [63:0] va [64];
  logic [63:0] vb [64];
  logic [63:0] m_mask = '0;
  logic        m_on = 1'b0;
  int          m_vl = 64;

  always #10 clk = ~clk;

  vcm_unit i_vcm_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_cond(cmd_cond), .cmd_vs(cmd_vs), .cmd_scalar(cmd_scalar),
    .src_valid(src_valid), .src_ready(src_ready), .src_a(src_a), .src_b(src_b),
    .mask_bits(mask_bits), .mask_on(mask_on), .done(done), .pop_valid(pop_valid),
    .pop_count(pop_count), .lane_idx(lane_idx), .lane_we(lane_we)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic ref_hit(input int cc, input logic [63:0] a, input logic [63:0] b);
    case (cc)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) > $signed(b);
      3: return $signed(a) < $signed(b);
      4: return $signed(a) >= $signed(b);
      5: return $signed(a) <= $signed(b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic int ones_below(input logic [63:0] m, input int vl);
    int c = 0;
    for (int k = 0; k < 64; k++) if (k < vl && m[k]) c++;
    return c;
  endfunction

  // Issue one command; returns at the falling edge after acceptance.
  task automatic send_cmd(input logic [1:0] op, input logic [2:0] cc,
                          input logic vs, input logic [63:0] sc);
    cmd_valid = 1'b1; cmd_op = op; cmd_cond = cc; cmd_vs = vs; cmd_scalar = sc;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_len(input int n);
    send_cmd(2'd3, 3'd0, 1'b0, 64'(n));
    m_vl = (n > 64) ? 64 : n;
  endtask

  // Run one compare over va/vb; gap>0 inserts an idle cycle every gap beats.
  task automatic run_cmp(input int cc, input logic vs, input logic [63:0] sc,
                         input int gap, input string tag);
    logic [63:0] exp_m = '0;
    int bad_hs = 0;
    int early_done = 0;
    for (int i = 0; i < m_vl; i++)
      exp_m[i] = ref_hit(cc, va[i], vs ? sc : vb[i]);
    send_cmd(2'd0, 3'(cc), vs, sc);
    if (m_vl == 0) begin
      chk({tag, " R9 zero-length done"}, 64'(done), 64'd1);
      chk({tag, " R9 zero-length no beat"}, 64'(src_ready), 64'd0);
    end else begin
      for (int i = 0; i < m_vl; i++) begin
        if (gap > 0 && (i % gap) == 1) begin
          src_valid = 1'b0;
          @(posedge clk); @(negedge clk);
        end
        if (!src_ready || cmd_ready) bad_hs++;
        if (done) early_done++;
        src_valid = 1'b1; src_a = va[i]; src_b = vb[i];
        @(posedge clk); @(negedge clk);
      end
      src_valid = 1'b0;
      chk({tag, " R8 ready only while active"}, 64'(bad_hs), 64'd0);
      chk({tag, " R9 no early done"}, 64'(early_done), 64'd0);
      chk({tag, " R9 done after last beat"}, 64'(done), 64'd1);
      chk({tag, " R8 idle after last beat"}, 64'({src_ready, cmd_ready}), 64'b01);
      @(posedge clk); @(negedge clk);
      chk({tag, " R9 done one cycle"}, 64'(done), 64'd0);
    end
    chk({tag, " R3 mask"}, mask_bits, exp_m);
    chk({tag, " R3 mask_on"}, 64'(mask_on), 64'd1);
    m_mask = exp_m; m_on = 1'b1;
  endtask

  task automatic check_pop(input string tag);
    send_cmd(2'd1, 3'd0, 1'b0, 64'd0);
    chk({tag, " R6 pop_valid"}, 64'(pop_valid), 64'd1);
    chk({tag, " R6 pop_count"}, 64'(pop_count), 64'(ones_below(m_mask, m_vl)));
    @(posedge clk); @(negedge clk);
    chk({tag, " R6 pop_valid one cycle"}, 64'(pop_valid), 64'd0);
  endtask

  task automatic scan_lane(input string tag);
    int bad = 0;
    for (int i = 0; i < 64; i++) begin
      lane_idx = 6'(i);
      #1;
      if (lane_we !== ((i < m_vl) && (!m_on || m_mask[i]))) bad++;
    end
    chk({tag, " R4 lane_we scan"}, 64'(bad), 64'd0);
  endtask

  task automatic t_reset();
    chk("R10 cmd_ready", 64'(cmd_ready), 64'd1);
    chk("R10 idle outputs", 64'({src_ready, done, pop_valid, mask_on}), 64'd0);
    chk("R10 mask clear", mask_bits, 64'd0);
    check_pop("R7 reset length");
  endtask

  task automatic t_full_vv();
    for (int i = 0; i < 64; i++) begin
      va[i] = 64'(i * 37 + 5);
      vb[i] = (i % 3 == 0) ? va[i] : 64'(i * 11);
    end
    run_cmp(0, 1'b0, 64'd0, 0, "full EQ");
    check_pop("full EQ");
    scan_lane("masked full");
  endtask

  task automatic t_signed_conds();
    set_len(16);
    for (int i = 0; i < 16; i++) begin
      va[i] = (i % 2) ? -64'(i) : 64'(i);
      vb[i] = (i % 4 == 0) ? va[i] : 64'h8000_0000_0000_0000 ^ 64'(i);
    end
    va[3] = 64'h8000_0000_0000_0000;
    for (int cc = 0; cc < 8; cc++) run_cmp(cc, 1'b0, 64'd0, 0, "R1 vv cond");
    for (int cc = 0; cc < 8; cc++) run_cmp(cc, 1'b1, 64'(-3), 0, "R2 vs cond");
    run_cmp(2, 1'b1, 64'd4, 0, "R2 vs positive scalar");
    check_pop("R2 vs");
  endtask

  task automatic t_short_len();
    for (int i = 0; i < 64; i++) begin va[i] = 64'd9; vb[i] = 64'd1; end
    set_len(10);
    run_cmp(2, 1'b0, 64'd0, 0, "R3 short GT");
    scan_lane("short masked");
    run_cmp(4, 1'b0, 64'd0, 0, "R3 short GE");
    set_len(64);
    check_pop("R6 after length grows");
    set_len(6);
    check_pop("R6 length limits count");
  endtask

  task automatic t_clear();
    send_cmd(2'd2, 3'd0, 1'b0, 64'd0);
    m_mask = '0; m_on = 1'b0;
    chk("R5 mask cleared", mask_bits, 64'd0);
    chk("R5 masking off", 64'(mask_on), 64'd0);
    scan_lane("R5 unmasked");
    set_len(40);
    scan_lane("R7 unmasked len 40");
  endtask

  task automatic t_clamp_and_gaps();
    for (int i = 0; i < 64; i++) begin
      va[i] = 64'(i);
      vb[i] = 64'(63 - i);
    end
    set_len(200);
    run_cmp(3, 1'b0, 64'd0, 5, "R7 clamp gaps LT");
    check_pop("R7 clamp");
    set_len(64'hFFFF_0000_0000_0040);
    run_cmp(5, 1'b0, 64'd0, 2, "R8 huge length gaps LE");
  endtask

  task automatic t_zero_len();
    set_len(0);
    run_cmp(1, 1'b0, 64'd0, 0, "R9 zero");
    check_pop("R9 zero");
    scan_lane("R4 zero length");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_vv();
    t_signed_conds();
    t_short_len();
    t_clear();
    t_clamp_and_gaps();
    t_zero_len();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule